// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Receiver

This block is the receive side of a UART node on a shared multi-drop line. The characters on the line are nine bits long: eight data bits and an extra bit that tells whether the character is an address or data. The receiver oversamples the line and rebuilds each character. In automatic mode it compares every address character with the node's own address. It then passes on only the data characters that follow a matching address, so a node that was not addressed sees no traffic at all. In software mode the block hands every character to the host and marks the address characters, so the host does the comparison itself.

The block also sequences the line driver for half-duplex use. When the local transmitter asks to send, the block enables the driver, waits one bit time and then tells the transmitter to start. It keeps the driver enabled until the character's stop bit has ended. While it drives the line, the receiver is held idle so that the node does not hear its own transmission.

Top module: `uart9_addr_rx`

## Requirements
- R1: The sample tick runs every DIV clocks and there are OSR ticks per bit. A low level is treated as a start bit only if it is still low OSR/2 ticks after it was first seen. The nine bits then follow the start bit, least significant first: bits 0..7 are data and bit 8 is the address flag. Each bit is sampled at its centre, and a stop bit follows.
- R2: In automatic mode (`cfg_auto_en`=1), a character with bit 8 = 1 whose low byte equals `cfg_own_addr` selects the node. Address characters never raise `rx_valid_o` in this mode.
- R3: In automatic mode, a character with bit 8 = 0 that arrives while the node is selected is delivered. `rx_valid_o` is high for exactly one clock, `rx_data_o` holds the byte and `rx_is_addr_o` is 0.
- R4: In automatic mode, an address character whose low byte differs from `cfg_own_addr` deselects the node. Data characters are then dropped until a matching address arrives.
- R5: In software mode (`cfg_auto_en`=0), every character is delivered, and `rx_is_addr_o` carries its bit 8.
- R6: A stop bit sampled low raises `rx_ferr_o` for one clock, and the character is not delivered. The receiver accepts a new start bit only after the line has returned high.
- R7: A low pulse shorter than half a bit time on an idle line produces no delivery and no framing error.
- R8: With `cfg_hd_en`=1, a `tx_go_i` pulse raises `de_o` on the next clock edge. `tx_launch_o` pulses exactly BIT_CLKS = OSR*DIV clocks later. `de_o` then stays high for CHAR_CLKS = 11*BIT_CLKS clocks more before it falls.
- R9: With `cfg_hd_en`=1 and `de_o` high, the receiver is held idle. A character in progress is abandoned without a delivery or a framing error.
- R10: With `cfg_hd_en`=0, `de_o` is constantly 1, and `tx_launch_o` pulses on the clock edge that samples `tx_go_i`.
- R11: After reset, `rx_valid_o`, `rx_ferr_o` and `tx_launch_o` are 0 and the node is deselected. With `cfg_hd_en`=1, `de_o` is 0.
- R12: While `cfg_auto_en`=0, the selection is cleared. On return to automatic mode, data is dropped until a matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| cfg_own_addr | input | 8 | Address of this node |
| cfg_auto_en | input | 1 | 1: hardware address match, 0: deliver every character |
| cfg_hd_en | input | 1 | 1: half-duplex driver sequencing |
| tx_go_i | input | 1 | Request from the local transmitter to send one character |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-clock strobe for a delivered byte |
| rx_is_addr_o | output | 1 | Delivered byte was an address character |
| rx_ferr_o | output | 1 | One-clock framing error strobe |
| de_o | output | 1 | Line driver enable |
| tx_launch_o | output | 1 | One-clock start strobe to the local transmitter |

## Verification
A transmit request and a receive can overlap: `tx_go_i` can arrive while a character is halfway through the deframer. In that cycle the driver enable rises and the receiver must drop the partial character. The bench starts a character and issues the request five bit times into it. It then judges that no byte and no framing error come out, and that the launch strobe still arrives exactly one bit time after the enable rose. It also counts how long the enable stays high.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_RECOV
  } rx_state_t;

  typedef enum logic [1:0] {
    DE_IDLE,
    DE_LEAD,
    DE_BUSY
  } de_state_t;
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart9_deframe.sv
module uart9_deframe
  import uart9_pkg::*;
#(
  parameter int OSR = 16,
  parameter int NB  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          hold_i,
  output logic          done_o,
  output logic          ferr_o,
  output logic [NB-1:0] chr_o
);
  localparam int SCW  = $clog2(OSR);
  localparam int BNW  = $clog2(NB);
  localparam int HALF = OSR / 2;

  logic rx_meta_q, rx_s_q;
  rx_state_t st_q, st_d;
  logic [SCW-1:0] sc_q, sc_d;
  logic [BNW-1:0] bn_q, bn_d;
  logic [NB-1:0]  sh_q, sh_d;
  logic done_d, ferr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta_q <= 1'b1;
      rx_s_q    <= 1'b1;
    end else begin
      rx_meta_q <= rx_i;
      rx_s_q    <= rx_meta_q;
    end
  end

  always_comb begin
    st_d   = st_q;
    sc_d   = sc_q;
    bn_d   = bn_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ferr_d = 1'b0;
    if (hold_i) begin
      st_d = RX_IDLE;
      sc_d = '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (tick_i && !rx_s_q) begin
            st_d = RX_START;
            sc_d = '0;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (sc_q == SCW'(HALF - 1)) begin
              sc_d = '0;
              bn_d = '0;
              st_d = rx_s_q ? RX_IDLE : RX_BITS;
            end else begin
              sc_d = sc_q + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick_i) begin
            if (sc_q == SCW'(OSR - 1)) begin
              sc_d = '0;
              sh_d = {rx_s_q, sh_q[NB-1:1]};
              if (bn_q == BNW'(NB - 1)) st_d = RX_STOP;
              else                      bn_d = bn_q + 1'b1;
            end else begin
              sc_d = sc_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick_i) begin
            if (sc_q == SCW'(OSR - 1)) begin
              sc_d = '0;
              if (rx_s_q) begin
                done_d = 1'b1;
                st_d   = RX_IDLE;
              end else begin
                ferr_d = 1'b1;
                st_d   = RX_RECOV;
              end
            end else begin
              sc_d = sc_q + 1'b1;
            end
          end
        end
        RX_RECOV: begin
          if (rx_s_q) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sc_q   <= '0;
      bn_q   <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      sc_q   <= sc_d;
      bn_q   <= bn_d;
      sh_q   <= sh_d;
      done_o <= done_d;
      ferr_o <= ferr_d;
    end
  end

  assign chr_o = sh_q;
endmodule

// File: rtl/uart9_filter.sv
module uart9_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          ferr_i,
  input  logic [DW:0]   chr_i,
  input  logic [DW-1:0] own_i,
  input  logic          auto_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          is_addr_o,
  output logic          ferr_o
);
  logic          sel_q, sel_d;
  logic          val_d, adr_d;
  logic [DW-1:0] dat_d;
  logic          addr_flag;

  assign addr_flag = chr_i[DW];

  always_comb begin
    sel_d = auto_i ? sel_q : 1'b0;
    val_d = 1'b0;
    adr_d = 1'b0;
    dat_d = data_o;
    if (done_i) begin
      if (auto_i) begin
        if (addr_flag) begin
          sel_d = (chr_i[DW-1:0] == own_i);
        end else if (sel_q) begin
          val_d = 1'b1;
          dat_d = chr_i[DW-1:0];
        end
      end else begin
        val_d = 1'b1;
        adr_d = addr_flag;
        dat_d = chr_i[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      valid_o   <= 1'b0;
      is_addr_o <= 1'b0;
      data_o    <= '0;
      ferr_o    <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      valid_o   <= val_d;
      is_addr_o <= adr_d;
      data_o    <= dat_d;
      ferr_o    <= ferr_i;
    end
  end
endmodule

// File: rtl/uart9_de_ctrl.sv
module uart9_de_ctrl
  import uart9_pkg::*;
#(
  parameter int BIT_CLKS  = 32,
  parameter int CHAR_CLKS = 352
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hd_en_i,
  input  logic go_i,
  output logic de_o,
  output logic hold_o,
  output logic launch_o
);
  localparam int CW = $clog2(BIT_CLKS + CHAR_CLKS + 1);

  de_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic launch_d;
  logic active;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    launch_d = 1'b0;
    case (st_q)
      DE_IDLE: begin
        if (go_i) begin
          if (hd_en_i) begin
            st_d  = DE_LEAD;
            cnt_d = '0;
          end else begin
            launch_d = 1'b1;
          end
        end
      end
      DE_LEAD: begin
        if (cnt_q == CW'(BIT_CLKS - 1)) begin
          st_d     = DE_BUSY;
          cnt_d    = '0;
          launch_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      DE_BUSY: begin
        if (cnt_q == CW'(CHAR_CLKS - 1)) st_d = DE_IDLE;
        else                             cnt_d = cnt_q + 1'b1;
      end
      default: st_d = DE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= DE_IDLE;
      cnt_q    <= '0;
      launch_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      launch_o <= launch_d;
    end
  end

  assign active = (st_q != DE_IDLE);
  assign de_o   = !hd_en_i || active;
  assign hold_o = hd_en_i && active;
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic [DW-1:0] cfg_own_addr,
  input  logic          cfg_auto_en,
  input  logic          cfg_hd_en,
  input  logic          tx_go_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          rx_is_addr_o,
  output logic          rx_ferr_o,
  output logic          de_o,
  output logic          tx_launch_o
);
  localparam int NB        = DW + 1;
  localparam int BIT_CLKS  = OSR * DIV;
  localparam int CHAR_CLKS = (NB + 2) * BIT_CLKS;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          tick;
  logic          hold;
  logic          done;
  logic          ferr;
  logic [NB-1:0] chr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart9_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  uart9_deframe #(.OSR(OSR), .NB(NB)) u_deframe (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rx_i   (rx_i),
    .tick_i (tick),
    .hold_i (hold),
    .done_o (done),
    .ferr_o (ferr),
    .chr_o  (chr)
  );

  uart9_filter #(.DW(DW)) u_filter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .done_i    (done),
    .ferr_i    (ferr),
    .chr_i     (chr),
    .own_i     (cfg_own_addr),
    .auto_i    (cfg_auto_en),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .is_addr_o (rx_is_addr_o),
    .ferr_o    (rx_ferr_o)
  );

  uart9_de_ctrl #(.BIT_CLKS(BIT_CLKS), .CHAR_CLKS(CHAR_CLKS)) u_de (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hd_en_i  (cfg_hd_en),
    .go_i     (tx_go_i),
    .de_o     (de_o),
    .hold_o   (hold),
    .launch_o (tx_launch_o)
  );
endmodule

// File: rtl/uart9_addr_rx_chk.sv
module uart9_addr_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_auto_en,
  input logic          cfg_hd_en,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_valid_o,
  input logic          rx_is_addr_o,
  input logic          rx_ferr_o,
  input logic          de_o,
  input logic          tx_launch_o
);
  a_r6_ferr_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_o && rx_ferr_o));

  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r2_no_addr_in_auto: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_auto_en) && rx_valid_o) |-> !rx_is_addr_o);

  a_r8_de_before_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hd_en && $past(cfg_hd_en) && tx_launch_o) |-> $past(de_o));

  a_r8_de_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hd_en && tx_launch_o) |=> de_o);

  a_r6_ferr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr_o |=> !rx_ferr_o);
endmodule

bind uart9_addr_rx uart9_addr_rx_chk #(.DW(DW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_auto_en  (cfg_auto_en),
  .cfg_hd_en    (cfg_hd_en),
  .rx_data_o    (rx_data_o),
  .rx_valid_o   (rx_valid_o),
  .rx_is_addr_o (rx_is_addr_o),
  .rx_ferr_o    (rx_ferr_o),
  .de_o         (de_o),
  .tx_launch_o  (tx_launch_o)
);

// File: tb/uart9_addr_rx_tb.sv
module uart9_addr_rx_tb_top;
  localparam int OSR   = 16;
  localparam int DIV   = 2;
  localparam int BITC  = OSR * DIV;
  localparam int CHARC = 11 * BITC;

  logic       clk;
  logic       rst_n;
  logic       rx;
  logic [7:0] own;
  logic       auto_en;
  logic       hd_en;
  logic       tx_go;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_is_addr;
  logic       rx_ferr;
  logic       de;
  logic       launch;

  int checks = 0;
  int errors = 0;
  int n_val  = 0;
  int n_ferr = 0;
  logic [7:0] got_d [0:63];
  logic       got_a [0:63];
  bit         finished = 0;

  uart9_addr_rx #(.DW(8), .OSR(OSR), .DIV(DIV)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx),
    .cfg_own_addr (own),
    .cfg_auto_en  (auto_en),
    .cfg_hd_en    (hd_en),
    .tx_go_i      (tx_go),
    .rx_data_o    (rx_data),
    .rx_valid_o   (rx_valid),
    .rx_is_addr_o (rx_is_addr),
    .rx_ferr_o    (rx_ferr),
    .de_o         (de),
    .tx_launch_o  (launch)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        got_d[n_val[5:0]] = rx_data;
        got_a[n_val[5:0]] = rx_is_addr;
        n_val++;
      end
      if (rx_ferr) n_ferr++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_char(input logic [8:0] c, input logic stop_ok);
    rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rx = c[i];
      repeat (BITC) @(negedge clk);
    end
    rx = stop_ok;
    repeat (BITC) @(negedge clk);
    rx = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic pulse_go_measure(output int k);
    tx_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_go = 1'b0;
    k = 0;
    while (!launch && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset();
    check(rx_valid == 1'b0, "R11", "valid after reset", int'(rx_valid), 0);
    check(rx_ferr == 1'b0, "R11", "ferr after reset", int'(rx_ferr), 0);
    check(launch == 1'b0, "R11", "launch after reset", int'(launch), 0);
    check(de == 1'b0, "R11", "de after reset", int'(de), 0);
    // R11: deselected after reset, so data is dropped
    begin
      int b = n_val;
      send_char({1'b0, 8'h66}, 1'b1);
      check(n_val == b, "R11", "data dropped while deselected", n_val - b, 0);
    end
  endtask

  task automatic t_auto_match();
    int b = n_val;
    auto_en = 1'b1;
    send_char({1'b1, 8'h5A}, 1'b1);
    check(n_val == b, "R2", "own address not delivered", n_val - b, 0);
    send_char({1'b0, 8'h3C}, 1'b1);
    send_char({1'b0, 8'hA5}, 1'b1);
    check(n_val == b + 2, "R3", "data after match delivered", n_val - b, 2);
    check(got_d[b[5:0]] == 8'h3C, "R1", "first byte value", int'(got_d[b[5:0]]), 'h3C);
    check(got_d[b[5:0]+6'd1] == 8'hA5, "R1", "second byte value",
          int'(got_d[b[5:0]+6'd1]), 'hA5);
    check(got_a[b[5:0]] == 1'b0, "R3", "data flag clear", int'(got_a[b[5:0]]), 0);
  endtask

  task automatic t_auto_other();
    int b = n_val;
    send_char({1'b1, 8'h11}, 1'b1);
    send_char({1'b0, 8'h77}, 1'b1);
    send_char({1'b0, 8'h78}, 1'b1);
    check(n_val == b, "R4", "data after foreign address dropped", n_val - b, 0);
    send_char({1'b1, 8'h5A}, 1'b1);
    send_char({1'b0, 8'h0F}, 1'b1);
    check(n_val == b + 1, "R4", "reselect by own address", n_val - b, 1);
    check(got_d[b[5:0]] == 8'h0F, "R4", "byte after reselect", int'(got_d[b[5:0]]), 'h0F);
  endtask

  task automatic t_sw_mode();
    int b = n_val;
    auto_en = 1'b0;
    send_char({1'b1, 8'h11}, 1'b1);
    send_char({1'b0, 8'h22}, 1'b1);
    send_char({1'b1, 8'h5A}, 1'b1);
    check(n_val == b + 3, "R5", "software mode delivers all", n_val - b, 3);
    check(got_a[b[5:0]] == 1'b1 && got_d[b[5:0]] == 8'h11, "R5", "first address",
          int'(got_d[b[5:0]]), 'h11);
    check(got_a[b[5:0]+6'd1] == 1'b0 && got_d[b[5:0]+6'd1] == 8'h22, "R5", "data between",
          int'(got_d[b[5:0]+6'd1]), 'h22);
    check(got_a[b[5:0]+6'd2] == 1'b1, "R5", "own address flagged",
          int'(got_a[b[5:0]+6'd2]), 1);
    b = n_val;
    auto_en = 1'b1;
    send_char({1'b0, 8'h33}, 1'b1);
    check(n_val == b, "R12", "selection cleared by software mode", n_val - b, 0);
  endtask

  task automatic t_ferr();
    int b  = n_val;
    int bf = n_ferr;
    auto_en = 1'b0;
    send_char({1'b0, 8'h44}, 1'b0);
    check(n_ferr == bf + 1, "R6", "framing error strobe", n_ferr - bf, 1);
    check(n_val == b, "R6", "bad character not delivered", n_val - b, 0);
    send_char({1'b0, 8'h45}, 1'b1);
    check(n_val == b + 1 && got_d[b[5:0]] == 8'h45, "R6", "recovery after error",
          n_val - b, 1);
  endtask

  task automatic t_glitch();
    int b  = n_val;
    int bf = n_ferr;
    rx = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    check(n_val == b && n_ferr == bf, "R7", "short low pulse ignored", n_val - b, 0);
    send_char({1'b0, 8'h81}, 1'b1);
    check(n_val == b + 1 && got_d[b[5:0]] == 8'h81, "R7", "good char after glitch",
          int'(got_d[b[5:0]]), 'h81);
  endtask

  task automatic t_hd_timing();
    int k;
    int m;
    hd_en = 1'b1;
    @(negedge clk);
    check(de == 1'b0, "R8", "de low before request", int'(de), 0);
    tx_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_go = 1'b0;
    check(de == 1'b1, "R8", "de high after request", int'(de), 1);
    k = 0;
    while (!launch && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(k == BITC, "R8", "launch one bit after de", k, BITC);
    m = 0;
    while (de && m < 2000) begin
      @(negedge clk);
      m++;
    end
    check(m == CHARC, "R8", "de hold after launch", m, CHARC);
  endtask

  task automatic t_hd_mute();
    int b  = n_val;
    int bf = n_ferr;
    int k  = 0;
    auto_en = 1'b0;
    fork
      send_char({1'b0, 8'hC3}, 1'b1);
      begin
        repeat (5 * BITC) @(negedge clk);
        pulse_go_measure(k);
      end
    join
    while (de) @(negedge clk);
    repeat (BITC) @(negedge clk);
    check(k == BITC, "R8", "launch timing during receive", k, BITC);
    check(n_val == b, "R9", "receive abandoned under de", n_val - b, 0);
    check(n_ferr == bf, "R9", "no framing error under de", n_ferr - bf, 0);
    send_char({1'b0, 8'h3D}, 1'b1);
    check(n_val == b + 1 && got_d[b[5:0]] == 8'h3D, "R9", "receive resumes after de",
          n_val - b, 1);
  endtask

  task automatic t_full();
    int k;
    hd_en = 1'b0;
    @(negedge clk);
    check(de == 1'b1, "R10", "de constant in full duplex", int'(de), 1);
    pulse_go_measure(k);
    check(k == 0, "R10", "immediate launch", k, 0);
    @(negedge clk);
    check(launch == 1'b0 && de == 1'b1, "R10", "single launch, de held",
          int'(launch), 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    rx      = 1'b1;
    own     = 8'h5A;
    auto_en = 1'b1;
    hd_en   = 1'b1;
    tx_go   = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_auto_match();
    t_auto_other();
    t_sw_mode();
    t_ferr();
    t_glitch();
    t_hd_timing();
    t_hd_mute();
    t_full();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule